// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a page table held in memory. Before the walk, a low-region relocation step adds the process identifier to small addresses. While it walks, the block applies a two-bit domain access field and a two-bit permission field. It finishes each request with a one-cycle completion pulse. At that point it presents either a physical address with read and write permission flags, or a fault. Fault status and the original virtual address are captured in one of two register pairs. Instruction fetches use one pair and all other accesses use the other.

A requester raises `req_valid` for one cycle while the walker is idle. The configuration inputs must stay steady until `done`. Descriptor reads go out one at a time: `mem_req` stays high with `mem_addr` until the memory answers with `mem_rsp_valid` and a 32-bit word.

Top module: `pt_walker`

## Requirements
- R1: Reset clears all of the following: the completion pulse, the memory request, the result fault flag, the physical address, both permission flags and all four fault registers. A reset that arrives in the middle of a walk abandons the walk.
- R2: An address below 0x02000000 has `cfg_pid` added to it before translation and before bypass. The fault address registers always receive the address exactly as presented on `req_va`.
- R3: When `cfg_ctrl` bit 0 is 0, no descriptor is read. The result carries the relocated address with both permission flags set, and the walk completes in the cycle after the request.
- R4: The first descriptor is read from {`cfg_tbase`[31:14], VA[31:20], 2'b00}. A first-level type (bits 1:0) of 0 produces fault code 5.
- R5: The domain is taken from descriptor bits 8:5, and its field is `cfg_dac` bits [2d+1:2d]. Field 0 or 2 produces fault code 9 for a section (type 2) or 11 for a table (type 1 coarse, type 3 fine). Field 3 grants read and write without a permission check.
- R6: A section maps to {descriptor[31:20], VA[19:0]}, and its permission field is descriptor bits 11:10.
- R7: The second descriptor is read from {first descriptor[31:10], VA[19:12], 2'b00}. Type 1 maps {d[31:16], VA[15:0]} and type 2 maps {d[31:12], VA[11:0]}. Both take their permission field from d[4+2*VA[11:10] +: 2].
- R8: A second-level type 0 produces fault code 7. Type 3 maps {d[31:10], VA[9:0]} with permission d[5:4] when reached through a fine table, and produces code 7 when reached through a coarse table.
- R9: Permission 1 gives read and write to privileged requests and nothing to user requests. Permission 2 gives read and write to privileged requests and read only to user requests. Permission 3 gives read and write to all.
- R10: Permission 0 denies writes. For reads it depends on `cfg_ctrl`. If only bit 8 is set, only privileged reads are allowed. If only bit 9 is set, all reads are allowed. If neither or both are set, nothing is allowed.
- R11: A denied access produces fault code 13 for a section or 15 for a page, and both permission flags are 0 on every fault.
- R12: A fault writes the status {domain, code} (bits 7:4 and 3:0) and the original VA into the instruction pair when `req_kind` is 2 (0 is read, 1 is write). Otherwise it writes them into the data pair. A successful walk leaves all four registers unchanged.
- R13: `mem_req` holds until `mem_rsp_valid`. A section needs one read and a page needs two. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (sampled while idle) |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_priv | input | 1 | 1 for a privileged request |
| cfg_ctrl | input | 32 | Control: bit 0 enable, bit 8 system, bit 9 ROM |
| cfg_tbase | input | 32 | First-level table base |
| cfg_dac | input | 32 | Sixteen two-bit domain access fields |
| cfg_pid | input | 32 | Process identifier used for relocation |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor word valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk faulted |
| pa | output | 32 | Physical address of the last successful walk |
| prot_rd | output | 1 | Read permitted |
| prot_wr | output | 1 | Write permitted |
| fsr_data | output | 8 | Data fault status {domain, code} |
| far_data | output | 32 | Data fault address |
| fsr_inst | output | 8 | Instruction fault status {domain, code} |
| far_inst | output | 32 | Instruction fault address |

## Verification
Some properties are checked on every cycle:
- the completion pulse lasts one cycle, and no descriptor request is open while it is high;
- an open request holds until it is answered;
- a faulted result carries no permission;
- a successful walk leaves all four fault registers untouched;
- the request and completion lines are low right after reset.

The address arithmetic needs the bench's table of descriptors and expected results. That covers relocation, the two descriptor address formulas, the per-subpage permission selection, the fault codes, routing between the two register pairs, and the permission-0 cases that depend on the control bits. The bench also shows the descriptor-read count, the effect of slow memory, and a reset in the middle of a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int AW    = 32;
    localparam int CODE_W = 4;
    localparam int DOM_W  = 4;
    localparam int FSR_W  = CODE_W + DOM_W;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_SYS = 8;
    localparam int CTRL_ROM = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1,
        ST_L2,
        ST_CHECK,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        L1_NONE    = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } l1_type_e;

    typedef enum logic [1:0] {
        L2_NONE  = 2'd0,
        L2_LARGE = 2'd1,
        L2_SMALL = 2'd2,
        L2_TINY  = 2'd3
    } l2_type_e;

    localparam logic [CODE_W-1:0] FC_SECT_XLAT = 4'd5;
    localparam logic [CODE_W-1:0] FC_PAGE_XLAT = 4'd7;
    localparam logic [CODE_W-1:0] FC_SECT_DOM  = 4'd9;
    localparam logic [CODE_W-1:0] FC_PAGE_DOM  = 4'd11;
    localparam logic [CODE_W-1:0] FC_SECT_PERM = 4'd13;
    localparam logic [CODE_W-1:0] FC_PAGE_PERM = 4'd15;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [DOM_W-1:0]  dom;
        logic [AW-1:0]     pa;
        logic              rd;
        logic              wr;
    } walk_res_t;

    function automatic logic [AW-1:0] l1_desc_addr(logic [AW-1:0] tbase, logic [AW-1:0] va);
        return {tbase[31:14], va[31:20], 2'b00};
    endfunction

    function automatic logic [AW-1:0] l2_desc_addr(logic [21:0] tbl, logic [AW-1:0] va);
        return {tbl, va[19:12], 2'b00};
    endfunction

    function automatic logic [1:0] dom_field(logic [AW-1:0] dac, logic [DOM_W-1:0] dom);
        logic [AW-1:0] sh;
        sh = dac >> {dom, 1'b0};
        return sh[1:0];
    endfunction

    function automatic logic [1:0] sub_ap(logic [AW-1:0] d, logic [1:0] sel);
        logic [1:0] r;
        case (sel)
            2'd0:    r = d[5:4];
            2'd1:    r = d[7:6];
            2'd2:    r = d[9:8];
            default: r = d[11:10];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pw_reloc.sv
module pw_reloc
    import pt_walker_pkg::*;
#(
    parameter logic [AW-1:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic [AW-1:0] va_in,
    input  logic [AW-1:0] pid,
    output logic [AW-1:0] va_out
);
    always_comb begin
        if (va_in < RELOC_LIMIT) va_out = va_in + pid;
        else                     va_out = va_in;
    end
endmodule

// File: rtl/pw_perm.sv
module pw_perm (
    input  logic [1:0] ap,
    input  logic       mgr,
    input  logic       is_wr,
    input  logic       priv,
    input  logic       sys_bit,
    input  logic       rom_bit,
    output logic       rd,
    output logic       wr
);
    always_comb begin
        rd = 1'b0;
        wr = 1'b0;
        if (mgr) begin
            rd = 1'b1;
            wr = 1'b1;
        end else begin
            case (ap)
                2'd0: begin
                    if (!is_wr) begin
                        if (sys_bit && !rom_bit)      rd = priv;
                        else if (rom_bit && !sys_bit) rd = 1'b1;
                    end
                end
                2'd1: begin
                    rd = priv;
                    wr = priv;
                end
                2'd2: begin
                    rd = priv | !is_wr;
                    wr = priv;
                end
                default: begin
                    rd = 1'b1;
                    wr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/pw_fault_regs.sv
module pw_fault_regs
    import pt_walker_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             is_fetch,
    input  logic [FSR_W-1:0] status,
    input  logic [AW-1:0]    addr,
    output logic [FSR_W-1:0] fsr_d,
    output logic [AW-1:0]    far_d,
    output logic [FSR_W-1:0] fsr_i,
    output logic [AW-1:0]    far_i
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_d <= '0;
            far_d <= '0;
            fsr_i <= '0;
            far_i <= '0;
        end else if (wr_en) begin
            if (is_fetch) begin
                fsr_i <= status;
                far_i <= addr;
            end else begin
                fsr_d <= status;
                far_d <= addr;
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [1:0]  req_kind,
    input  logic        req_priv,
    input  logic [31:0] cfg_ctrl,
    input  logic [31:0] cfg_tbase,
    input  logic [31:0] cfg_dac,
    input  logic [31:0] cfg_pid,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic        fault,
    output logic [31:0] pa,
    output logic        prot_rd,
    output logic        prot_wr,
    output logic [7:0]  fsr_data,
    output logic [31:0] far_data,
    output logic [7:0]  fsr_inst,
    output logic [31:0] far_inst
);
    walk_st_e         st_q, st_d;
    walk_res_t        res_q, fin;
    logic             fin_go;
    logic [AW-1:0]    reloc_va, va_q, ova_q, pa_q, l2_pa;
    acc_e             kind_q;
    logic             priv_q, mgr_q, fine_q, page_q;
    logic [DOM_W-1:0] dom_q, l1_dom;
    logic [1:0]       ap_q, l2_ap, l1_dacc;
    logic [21:0]      tbl_q;
    l1_type_e         l1_type;
    l2_type_e         l2_type;
    logic             p_rd, p_wr;
    logic             unused_bits;

    assign unused_bits = ^{cfg_ctrl[31:10], cfg_ctrl[7:1], cfg_tbase[13:0], mem_rsp_data[3:2]};

    pw_reloc #(.RELOC_LIMIT(RELOC_LIMIT)) u_reloc (
        .va_in  (req_va),
        .pid    (cfg_pid),
        .va_out (reloc_va)
    );

    pw_perm u_perm (
        .ap      (ap_q),
        .mgr     (mgr_q),
        .is_wr   (kind_q == ACC_WRITE),
        .priv    (priv_q),
        .sys_bit (cfg_ctrl[CTRL_SYS]),
        .rom_bit (cfg_ctrl[CTRL_ROM]),
        .rd      (p_rd),
        .wr      (p_wr)
    );

    assign l1_type = l1_type_e'(mem_rsp_data[1:0]);
    assign l2_type = l2_type_e'(mem_rsp_data[1:0]);
    assign l1_dom  = mem_rsp_data[8:5];
    assign l1_dacc = dom_field(cfg_dac, l1_dom);

    always_comb begin
        case (l2_type)
            L2_LARGE: begin
                l2_pa = {mem_rsp_data[31:16], va_q[15:0]};
                l2_ap = sub_ap(mem_rsp_data, va_q[11:10]);
            end
            L2_SMALL: begin
                l2_pa = {mem_rsp_data[31:12], va_q[11:0]};
                l2_ap = sub_ap(mem_rsp_data, va_q[11:10]);
            end
            default: begin
                l2_pa = {mem_rsp_data[31:10], va_q[9:0]};
                l2_ap = mem_rsp_data[5:4];
            end
        endcase
    end

    always_comb begin
        st_d   = st_q;
        fin_go = 1'b0;
        fin    = '0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!cfg_ctrl[CTRL_EN]) begin
                        fin_go = 1'b1;
                        fin.pa = reloc_va;
                        fin.rd = 1'b1;
                        fin.wr = 1'b1;
                        st_d   = ST_DONE;
                    end else begin
                        st_d = ST_L1;
                    end
                end
            end
            ST_L1: begin
                if (mem_rsp_valid) begin
                    if (l1_type == L1_NONE) begin
                        fin_go    = 1'b1;
                        fin.fault = 1'b1;
                        fin.code  = FC_SECT_XLAT;
                        fin.dom   = l1_dom;
                        st_d      = ST_DONE;
                    end else if (!l1_dacc[0]) begin
                        fin_go    = 1'b1;
                        fin.fault = 1'b1;
                        fin.code  = (l1_type == L1_SECTION) ? FC_SECT_DOM : FC_PAGE_DOM;
                        fin.dom   = l1_dom;
                        st_d      = ST_DONE;
                    end else if (l1_type == L1_SECTION) begin
                        st_d = ST_CHECK;
                    end else begin
                        st_d = ST_L2;
                    end
                end
            end
            ST_L2: begin
                if (mem_rsp_valid) begin
                    if (l2_type == L2_NONE || (l2_type == L2_TINY && !fine_q)) begin
                        fin_go    = 1'b1;
                        fin.fault = 1'b1;
                        fin.code  = FC_PAGE_XLAT;
                        fin.dom   = dom_q;
                        st_d      = ST_DONE;
                    end else begin
                        st_d = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                fin_go = 1'b1;
                st_d   = ST_DONE;
                if (p_rd || p_wr) begin
                    fin.pa = pa_q;
                    fin.rd = p_rd;
                    fin.wr = p_wr;
                end else begin
                    fin.fault = 1'b1;
                    fin.code  = page_q ? FC_PAGE_PERM : FC_SECT_PERM;
                    fin.dom   = dom_q;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            res_q  <= '0;
            va_q   <= '0;
            ova_q  <= '0;
            kind_q <= ACC_READ;
            priv_q <= 1'b0;
            dom_q  <= '0;
            mgr_q  <= 1'b0;
            fine_q <= 1'b0;
            page_q <= 1'b0;
            tbl_q  <= '0;
            pa_q   <= '0;
            ap_q   <= '0;
        end else begin
            st_q <= st_d;
            if (fin_go) res_q <= fin;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= reloc_va;
                        ova_q  <= req_va;
                        kind_q <= acc_e'(req_kind);
                        priv_q <= req_priv;
                    end
                end
                ST_L1: begin
                    if (mem_rsp_valid) begin
                        dom_q  <= l1_dom;
                        mgr_q  <= (l1_dacc == 2'b11);
                        tbl_q  <= mem_rsp_data[31:10];
                        fine_q <= (l1_type == L1_FINE);
                        page_q <= (l1_type != L1_SECTION);
                        pa_q   <= {mem_rsp_data[31:20], va_q[19:0]};
                        ap_q   <= mem_rsp_data[11:10];
                    end
                end
                ST_L2: begin
                    if (mem_rsp_valid) begin
                        pa_q <= l2_pa;
                        ap_q <= l2_ap;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req  = (st_q == ST_L1) || (st_q == ST_L2);
    assign mem_addr = (st_q == ST_L1) ? l1_desc_addr(cfg_tbase, va_q) : l2_desc_addr(tbl_q, va_q);
    assign done     = (st_q == ST_DONE);
    assign fault    = res_q.fault;
    assign pa       = res_q.pa;
    assign prot_rd  = res_q.rd;
    assign prot_wr  = res_q.wr;

    pw_fault_regs u_fregs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fin_go && fin.fault),
        .is_fetch (kind_q == ACC_FETCH),
        .status   ({fin.dom, fin.code}),
        .addr     (ova_q),
        .fsr_d    (fsr_data),
        .far_d    (far_data),
        .fsr_i    (fsr_inst),
        .far_i    (far_inst)
    );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic        fault,
    input logic        prot_rd,
    input logic        prot_wr,
    input logic [7:0]  fsr_data,
    input logic [31:0] far_data,
    input logic [7:0]  fsr_inst,
    input logic [31:0] far_inst
);
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rsp_valid |=> mem_req);

    // R13
    done_no_req_chk: assert property (@(posedge clk) disable iff (rst) done |-> !mem_req);

    // R11
    fault_no_prot_chk: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> !prot_rd && !prot_wr);

    // R12
    ok_keeps_fregs_chk: assert property (@(posedge clk) disable iff (rst)
        done && !fault |-> $stable(fsr_data) && $stable(fsr_inst)
                           && $stable(far_data) && $stable(far_inst));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req && !done);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic [31:0] cfg_ctrl = '0;
    logic [31:0] cfg_tbase = 32'h0000_4000;
    logic [31:0] cfg_dac = 32'h0000_00C4;
    logic [31:0] cfg_pid = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault, prot_rd, prot_wr;
    logic [31:0] pa, far_data, far_inst;
    logic [7:0]  fsr_data, fsr_inst;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    int wait_cnt = 0;
    int nhs = 0;
    logic [7:0]  m_fsr_d = '0, m_fsr_i = '0;
    logic [31:0] m_far_d = '0, m_far_i = '0;

    always #10 clk = ~clk;

    pt_walker u_dut (.*);

    localparam int NMEM = 13;
    localparam logic [31:0] MEM_A [NMEM] = '{
        32'h448C, 32'h4490, 32'h4494, 32'h4498, 32'h449C, 32'h44A0, 32'h44C0,
        32'h8014, 32'h8040, 32'h8080, 32'h4500, 32'hC004, 32'h4540};
    localparam logic [31:0] MEM_D [NMEM] = '{
        32'h8A50_0C22, 32'h7770_0422, 32'h6660_0822, 32'h5550_0022, 32'h4440_0042,
        32'h3330_0462, 32'h0000_8021, 32'h9990_1BF2, 32'hABCD_0F71, 32'h1111_1403,
        32'h0000_C023, 32'h2222_2C33, 32'h0000_8041};

    function automatic logic [31:0] mem_lookup(logic [31:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < NMEM; i++) if (MEM_A[i] == a) r = MEM_D[i];
        return r;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req && !rst) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_rsp_data = mem_lookup(mem_addr);
                    mem_rsp_valid = 1'b1;
                    nhs++;
                end
            end
        end
    end

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pid;
        logic [31:0] ctrl;
        logic [1:0]  kind;
        logic        priv;
        logic        xf;
        logic [31:0] xpa;
        logic        xrd;
        logic        xwr;
        logic [7:0]  xfsr;
        logic [1:0]  xhs;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        // R6 section, permission 3, user write
        '{32'h1230_0456, 32'h0, 32'h1, 2'd1, 1'b0, 1'b0, 32'h8A50_0456, 1'b1, 1'b1, 8'h00, 2'd1, 8'd6},
        // R2 low address relocated by pid
        '{32'h0000_0456, 32'h1230_0000, 32'h1, 2'd0, 1'b1, 1'b0, 32'h8A50_0456, 1'b1, 1'b1, 8'h00, 2'd1, 8'd2},
        // R2 high address not relocated
        '{32'h1230_0456, 32'h1000_0000, 32'h1, 2'd0, 1'b0, 1'b0, 32'h8A50_0456, 1'b1, 1'b1, 8'h00, 2'd1, 8'd2},
        // R3 bypass with relocation
        '{32'h0100_0000, 32'h10, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0100_0010, 1'b1, 1'b1, 8'h00, 2'd0, 8'd3},
        // R3 bypass high address
        '{32'hDEAD_BEEC, 32'h10, 32'h0, 2'd1, 1'b0, 1'b0, 32'hDEAD_BEEC, 1'b1, 1'b1, 8'h00, 2'd0, 8'd3},
        // R9 permission 1 privileged write
        '{32'h1240_0010, 32'h0, 32'h1, 2'd1, 1'b1, 1'b0, 32'h7770_0010, 1'b1, 1'b1, 8'h00, 2'd1, 8'd9},
        // R9 R11 permission 1 user read faults 13
        '{32'h1240_0010, 32'h0, 32'h1, 2'd0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd11},
        // R9 permission 2 user read
        '{32'h1250_0020, 32'h0, 32'h1, 2'd0, 1'b0, 1'b0, 32'h6660_0020, 1'b1, 1'b0, 8'h00, 2'd1, 8'd9},
        // R11 permission 2 user write
        '{32'h1250_0020, 32'h0, 32'h1, 2'd1, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd11},
        // R9 permission 2 privileged write
        '{32'h1250_0020, 32'h0, 32'h1, 2'd1, 1'b1, 1'b0, 32'h6660_0020, 1'b1, 1'b1, 8'h00, 2'd1, 8'd9},
        // R10 system bit, privileged read
        '{32'h1260_0030, 32'h0, 32'h101, 2'd0, 1'b1, 1'b0, 32'h5550_0030, 1'b1, 1'b0, 8'h00, 2'd1, 8'd10},
        // R10 system bit, user read
        '{32'h1260_0030, 32'h0, 32'h101, 2'd0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd10},
        // R10 ROM bit, user read
        '{32'h1260_0030, 32'h0, 32'h201, 2'd0, 1'b0, 1'b0, 32'h5550_0030, 1'b1, 1'b0, 8'h00, 2'd1, 8'd10},
        // R10 ROM bit, privileged write
        '{32'h1260_0030, 32'h0, 32'h201, 2'd1, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd10},
        // R10 neither bit
        '{32'h1260_0030, 32'h0, 32'h001, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd10},
        // R10 both bits
        '{32'h1260_0030, 32'h0, 32'h301, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1D, 2'd1, 8'd10},
        // R5 section domain fault, domain 2
        '{32'h1270_0000, 32'h0, 32'h1, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h29, 2'd1, 8'd5},
        // R5 manager domain overrides permission 1
        '{32'h1280_0000, 32'h0, 32'h1, 2'd1, 1'b0, 1'b0, 32'h3330_0000, 1'b1, 1'b1, 8'h00, 2'd1, 8'd5},
        // R4 R12 unmapped, fetch goes to instruction pair
        '{32'h1290_0000, 32'h0, 32'h1, 2'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h05, 2'd1, 8'd4},
        // R12 relocated fault records original address
        '{32'h0000_0100, 32'h1290_0000, 32'h1, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h05, 2'd1, 8'd12},
        // R7 small page privileged read
        '{32'h1300_5C12, 32'h0, 32'h1, 2'd0, 1'b1, 1'b0, 32'h9990_1C12, 1'b1, 1'b1, 8'h00, 2'd2, 8'd7},
        // R7 R11 small page subpage 3 user write
        '{32'h1300_5C12, 32'h0, 32'h1, 2'd1, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1F, 2'd2, 8'd7},
        // R7 large page subpage 1 user read
        '{32'h1301_0400, 32'h0, 32'h1, 2'd0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 8'h1F, 2'd2, 8'd7},
        // R7 large page privileged write
        '{32'h1301_0400, 32'h0, 32'h1, 2'd1, 1'b1, 1'b0, 32'hABCD_0400, 1'b1, 1'b1, 8'h00, 2'd2, 8'd7},
        // R8 tiny page through coarse table
        '{32'h1302_0000, 32'h0, 32'h1, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h17, 2'd2, 8'd8},
        // R8 empty second-level entry
        '{32'h1303_0000, 32'h0, 32'h1, 2'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h17, 2'd2, 8'd8},
        // R8 tiny page through fine table
        '{32'h1400_1A5C, 32'h0, 32'h1, 2'd2, 1'b0, 1'b0, 32'h2222_2E5C, 1'b1, 1'b1, 8'h00, 2'd2, 8'd8},
        // R5 page domain fault, fetch
        '{32'h1500_0000, 32'h0, 32'h1, 2'd2, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 8'h2B, 2'd1, 8'd5}
    };

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int n;
        int hs0;
        string rq;
        rq = $sformatf("R%0d(vec %0d)", v.rq, idx);
        @(negedge clk);
        req_va = v.va; req_kind = v.kind; req_priv = v.priv;
        cfg_pid = v.pid; cfg_ctrl = v.ctrl;
        req_valid = 1'b1;
        hs0 = nhs;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 80) begin
            @(negedge clk);
            n++;
        end
        chk(done, rq, "done", 32'(done), 32'd1);
        chk(fault == v.xf, rq, "fault", 32'(fault), 32'(v.xf));
        if (!v.xf) chk(pa == v.xpa, rq, "pa", pa, v.xpa);
        chk(prot_rd == v.xrd, rq, "prot_rd", 32'(prot_rd), 32'(v.xrd));
        chk(prot_wr == v.xwr, rq, "prot_wr", 32'(prot_wr), 32'(v.xwr));
        // R13 descriptor read count
        chk((nhs - hs0) == int'(v.xhs), rq, "reads", 32'(nhs - hs0), 32'(v.xhs));
        if (v.xf) begin
            if (v.kind == 2'd2) begin m_fsr_i = v.xfsr; m_far_i = v.va; end
            else begin m_fsr_d = v.xfsr; m_far_d = v.va; end
        end
        // R12 fault register contents
        chk(fsr_data == m_fsr_d, rq, "fsr_data", 32'(fsr_data), 32'(m_fsr_d));
        chk(far_data == m_far_d, rq, "far_data", far_data, m_far_d);
        chk(fsr_inst == m_fsr_i, rq, "fsr_inst", 32'(fsr_inst), 32'(m_fsr_i));
        chk(far_inst == m_far_i, rq, "far_inst", far_inst, m_far_i);
        @(negedge clk);
        // R13 single-cycle completion
        chk(!done, rq, "done pulse", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !mem_req && !fault && !prot_rd && !prot_wr && pa == 0, "R1", "outputs",
            {26'd0, done, mem_req, fault, prot_rd, prot_wr, |pa}, 32'd0);
        chk(fsr_data == 0 && fsr_inst == 0 && far_data == 0 && far_inst == 0, "R1", "fault regs",
            far_data | far_inst | {24'd0, fsr_data | fsr_inst}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R13 slow memory: request held over several cycles
        lat = 3;
        run_vec(VECS[20], 100);
        run_vec(VECS[24], 101);
        lat = 0;

        // R1 reset in the middle of a walk
        lat = 30;
        @(negedge clk);
        req_va = 32'h1300_5C12; req_kind = 2'd0; req_priv = 1'b1; cfg_pid = 0; cfg_ctrl = 32'h1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req, "R13", "request open", 32'(mem_req), 32'd1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wait_cnt = 0;
        lat = 0;
        m_fsr_d = '0; m_fsr_i = '0; m_far_d = '0; m_far_i = '0;
        @(negedge clk);
        chk(!mem_req && !done, "R1", "walk abandoned", {30'd0, mem_req, done}, 32'd0);
        chk(fsr_data == 0 && fsr_inst == 0 && far_data == 0 && far_inst == 0, "R1", "fault regs cleared",
            far_data | far_inst | {24'd0, fsr_data | fsr_inst}, 32'd0);
        repeat (5) @(negedge clk);
        chk(!done, "R1", "no stray completion", 32'(done), 32'd0);

        run_vec(VECS[0], 102);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule